// File: doc/BRIEF.md
# Sigma-Delta Output Gain and Offset Trim Engine

This block sits directly behind the decimated output of a sigma-delta converter. It has two jobs. In calibration it averages a run of raw conversion words while the analog side holds a known input: positive full scale, negative full scale or zero. From those averages it derives a gain factor and an offset. A separate offset is kept for every setting of the programmable amplifier gain.

In normal operation, with correction enabled, each raw word first has the stored offset for the current gain setting added to it. The result is then divided by the stored gain in a bit-serial divider. With correction disabled, words pass through untouched.

A restart key written to the register port starts a settling window. The samples in that window are accepted and thrown away, so the first word after a converter restart is never used. Software drives everything through a small register port with a one-cycle read latency.

Top module: `adc_trim_engine`

## Requirements
- R1: With CTRL bit 0 (correction enable) clear and no settling or averaging in progress, an accepted input word appears unchanged on `out_data`, with `out_valid` high, in the cycle after acceptance.
- R2: A run averages 2^L samples. L is RUNLOG (address 1, bits [3:0]), reset value 4. Writes below 4 store 4 and writes above 8 store 8. The average is the sum shifted right arithmetically by L. Samples taken by a run produce no output.
- R3: GAIN (address 5) is unsigned with 14 fractional bits and resets to 16384. At the end of a positive (kind 1) or negative (kind 2) full-scale run, it becomes (Dp - Dn) / 2, with the division rounding down. Dp and Dn are the latest positive and negative averages, which reset to +16384 and -16384. A result below 1 leaves GAIN unchanged.
- R4: A CTRL write with bit 6 set starts a run of the kind in bits [5:4] (1 positive, 2 negative, 3 zero). It needs bit 0 set in the same write. A full-scale run also needs the gain setting in bits [3:1] to be 0. Otherwise the write starts nothing, and GAIN and STATUS stay unchanged.
- R5: A zero run (kind 3) stores the negated average as the offset for the gain setting latched at start, saturating -32768 to 32767. OFFSET (address 6) reads the offset of the current gain setting. All offsets reset to 0.
- R6: With correction enabled, the output is (raw + offset[gain setting]) * 16384 / GAIN, truncated toward zero.
- R7: The corrected output saturates to the signed 16-bit range [-32768, 32767].
- R8: `in_ready` is low while the divider works on a corrected sample.
- R9: Writing 0x5AF0 to KEY (address 3) makes the block accept and discard the next N samples without output. N is SETTLE (address 2, bits [7:0]), reset value 8. Any other KEY value has no effect.
- R10: STATUS (address 4) bit 0 is set when a run finishes and clears on a read of STATUS. A read therefore returns 1 once and then 0. Bit 1 reads high while a run is in progress.
- R11: `reg_rdata` carries the register addressed by a `reg_rd` pulse in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Raw sample valid |
| in_ready | output | 1 | Engine can take a sample |
| in_data | input | 16 | Raw signed conversion word |
| out_valid | output | 1 | One-cycle strobe for an output word |
| out_data | output | 16 | Corrected or passed-through signed word |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, one cycle after `reg_rd` |

## Verification
The assertions assume a few things about the environment:
- Register writes and reads never land on the same cycle.
- A new run is requested only while no run is active.
- `in_data` is held stable together with `in_valid` until the sample is accepted.

The stimulus keeps to these rules. It issues one register access at a time and waits a few cycles after the last sample of each run before touching the register port. It presents each sample only once `in_ready` is seen high, and drops `in_valid` right after the accepting edge. All output checks wait on `out_valid` rather than on a fixed cycle count.

// File: rtl/adc_trim_pkg.sv
package adc_trim_pkg;
  typedef enum logic [1:0] {
    CAL_NONE = 2'd0,
    CAL_POS  = 2'd1,
    CAL_NEG  = 2'd2,
    CAL_ZERO = 2'd3
  } cal_kind_t;

  localparam logic [2:0] A_CTRL   = 3'd0;
  localparam logic [2:0] A_RUNLOG = 3'd1;
  localparam logic [2:0] A_SETTLE = 3'd2;
  localparam logic [2:0] A_KEY    = 3'd3;
  localparam logic [2:0] A_STATUS = 3'd4;
  localparam logic [2:0] A_GAIN   = 3'd5;
  localparam logic [2:0] A_OFFSET = 3'd6;
endpackage

// File: rtl/adc_trim_regs.sv
module adc_trim_regs
  import adc_trim_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int PGA_W       = 3,
  parameter int LOG_W       = 4,
  parameter int RUN_LOG_MIN = 4,
  parameter int RUN_LOG_MAX = 8,
  parameter int SETTLE_W    = 8,
  parameter int SETTLE_DEF  = 8,
  parameter logic [DATA_W-1:0] KEY_VAL = 16'h5AF0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              corr_en,
  output logic [PGA_W-1:0]  pga,
  output logic [LOG_W-1:0]  run_log,
  output logic [SETTLE_W-1:0] settle,
  output logic              key_hit,
  output logic              start_req,
  output cal_kind_t         start_kind,
  output logic              cal_done,
  input  logic              cal_busy,
  input  logic              cal_fin,
  input  logic [DATA_W-1:0] gain_q,
  input  logic [DATA_W-1:0] off_cur
);
  localparam int KIND_LO = PGA_W + 1;
  localparam int START_B = PGA_W + 3;
  localparam int CTRL_W  = PGA_W + 3;

  logic [CTRL_W-1:0] ctrl_q;
  cal_kind_t         wr_kind;
  logic              wr_ctrl, start_ok;

  assign wr_ctrl  = reg_wr && (reg_addr == A_CTRL);
  assign wr_kind  = cal_kind_t'(reg_wdata[KIND_LO+1:KIND_LO]);
  assign start_ok = reg_wdata[START_B] && reg_wdata[0] && (wr_kind != CAL_NONE) &&
                    ((wr_kind == CAL_ZERO) || (reg_wdata[PGA_W:1] == '0)) && !cal_busy;

  assign corr_en = ctrl_q[0];
  assign pga     = ctrl_q[PGA_W:1];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q     <= '0;
      run_log    <= LOG_W'(RUN_LOG_MIN);
      settle     <= SETTLE_W'(SETTLE_DEF);
      key_hit    <= 1'b0;
      start_req  <= 1'b0;
      start_kind <= CAL_NONE;
    end else begin
      key_hit   <= reg_wr && (reg_addr == A_KEY) && (reg_wdata == KEY_VAL);
      start_req <= wr_ctrl && start_ok;
      if (wr_ctrl) begin
        ctrl_q     <= reg_wdata[CTRL_W-1:0];
        start_kind <= wr_kind;
      end
      if (reg_wr && reg_addr == A_RUNLOG) begin
        if (reg_wdata < DATA_W'(RUN_LOG_MIN))      run_log <= LOG_W'(RUN_LOG_MIN);
        else if (reg_wdata > DATA_W'(RUN_LOG_MAX)) run_log <= LOG_W'(RUN_LOG_MAX);
        else                                       run_log <= reg_wdata[LOG_W-1:0];
      end
      if (reg_wr && reg_addr == A_SETTLE) settle <= reg_wdata[SETTLE_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                                  cal_done <= 1'b0;
    else if (cal_fin)                         cal_done <= 1'b1;
    else if (reg_rd && reg_addr == A_STATUS)  cal_done <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        A_CTRL:   reg_rdata <= DATA_W'(ctrl_q);
        A_RUNLOG: reg_rdata <= DATA_W'(run_log);
        A_SETTLE: reg_rdata <= DATA_W'(settle);
        A_STATUS: reg_rdata <= DATA_W'({cal_busy, cal_done});
        A_GAIN:   reg_rdata <= gain_q;
        A_OFFSET: reg_rdata <= off_cur;
        default:  reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/adc_trim_avg.sv
module adc_trim_avg #(
  parameter int DATA_W  = 16,
  parameter int LOG_MAX = 8,
  parameter int LOG_W   = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic [LOG_W-1:0]         log_n,
  input  logic                     smp_valid,
  input  logic signed [DATA_W-1:0] smp_data,
  output logic                     active,
  output logic                     fin,
  output logic signed [DATA_W-1:0] avg
);
  localparam int ACC_W = DATA_W + LOG_MAX;
  localparam int CNT_W = LOG_MAX + 1;

  logic signed [ACC_W-1:0] acc, acc_n;
  logic [CNT_W-1:0]        cnt, cnt_n, target;
  logic [LOG_W-1:0]        k_q;

  assign acc_n  = acc + ACC_W'(smp_data);
  assign cnt_n  = cnt + CNT_W'(1);
  assign target = CNT_W'(1) << k_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      fin    <= 1'b0;
      acc    <= '0;
      cnt    <= '0;
      k_q    <= '0;
      avg    <= '0;
    end else begin
      fin <= 1'b0;
      if (start) begin
        active <= 1'b1;
        acc    <= '0;
        cnt    <= '0;
        k_q    <= log_n;
      end else if (active && smp_valid) begin
        acc <= acc_n;
        cnt <= cnt_n;
        if (cnt_n == target) begin
          active <= 1'b0;
          fin    <= 1'b1;
          avg    <= DATA_W'(acc_n >>> k_q);
        end
      end
    end
  end
endmodule

// File: rtl/adc_trim_div.sv
module adc_trim_div #(
  parameter int NUM_W = 31,
  parameter int DEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             busy,
  output logic             done,
  output logic [NUM_W-1:0] quo
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [DEN_W-1:0] rem, den_q;
  logic [DEN_W:0]   shifted, trial;
  logic [CNT_W-1:0] cnt;

  assign shifted = {rem, quo[NUM_W-1]};
  assign trial   = shifted - {1'b0, den_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      rem   <= '0;
      den_q <= '0;
      quo   <= '0;
      cnt   <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy  <= 1'b1;
        quo   <= num;
        den_q <= den;
        rem   <= '0;
        cnt   <= CNT_W'(NUM_W);
      end else if (busy) begin
        if (!trial[DEN_W]) begin
          rem <= trial[DEN_W-1:0];
          quo <= {quo[NUM_W-2:0], 1'b1};
        end else begin
          rem <= shifted[DEN_W-1:0];
          quo <= {quo[NUM_W-2:0], 1'b0};
        end
        cnt <= cnt - CNT_W'(1);
        if (cnt == CNT_W'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/adc_trim_engine.sv
module adc_trim_engine
  import adc_trim_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int FRAC_W      = 14,
  parameter int PGA_W       = 3,
  parameter int RUN_LOG_MIN = 4,
  parameter int RUN_LOG_MAX = 8,
  parameter int SETTLE_W    = 8,
  parameter int SETTLE_DEF  = 8,
  parameter logic [DATA_W-1:0] KEY_VAL = 16'h5AF0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata
);
  localparam int NPGA  = 1 << PGA_W;
  localparam int LOG_W = $clog2(RUN_LOG_MAX + 1);
  localparam int SUM_W = DATA_W + 1;
  localparam int NUM_W = SUM_W + FRAC_W;
  localparam logic signed [DATA_W-1:0] SMAX = DATA_W'((1 << (DATA_W - 1)) - 1);
  localparam logic signed [DATA_W-1:0] SMIN = ~SMAX;
  localparam logic [DATA_W-1:0] GAIN_ONE = DATA_W'(1 << FRAC_W);

  logic               corr_en, key_hit, start_req, cal_done;
  logic [PGA_W-1:0]   pga;
  logic [LOG_W-1:0]   run_log;
  logic [SETTLE_W-1:0] settle, disc_q;
  cal_kind_t          start_kind, kind_q;
  logic [PGA_W-1:0]   cal_pga_q;
  logic [DATA_W-1:0]  gain_q, off_cur;
  logic signed [DATA_W-1:0] pos_q, neg_q;

  logic               cal_active, avg_fin;
  logic signed [DATA_W-1:0] avg_val;

  logic               accept, take, smp_to_avg, div_go, pass_go;
  logic               div_busy, div_done, neg_q_flag;
  logic [NUM_W-1:0]   div_num, div_quo;
  logic signed [SUM_W-1:0] sum;
  logic [SUM_W-1:0]   mag;

  logic signed [DATA_W-1:0] off_mem [NPGA];
  logic [NPGA-1:0]          off_vld;

  // register port
  adc_trim_regs #(
    .DATA_W(DATA_W), .PGA_W(PGA_W), .LOG_W(LOG_W),
    .RUN_LOG_MIN(RUN_LOG_MIN), .RUN_LOG_MAX(RUN_LOG_MAX),
    .SETTLE_W(SETTLE_W), .SETTLE_DEF(SETTLE_DEF), .KEY_VAL(KEY_VAL)
  ) u_regs (
    .clk, .rst, .reg_wr, .reg_rd, .reg_addr, .reg_wdata, .reg_rdata,
    .corr_en, .pga, .run_log, .settle, .key_hit, .start_req, .start_kind,
    .cal_done, .cal_busy(cal_active), .cal_fin(avg_fin), .gain_q, .off_cur
  );

  // sample routing
  assign in_ready   = !div_busy;
  assign accept     = in_valid && in_ready;
  assign take       = accept && (disc_q == '0);
  assign smp_to_avg = take && cal_active;
  assign div_go     = take && !cal_active && corr_en;
  assign pass_go    = take && !cal_active && !corr_en;

  always_ff @(posedge clk) begin
    if (rst)                         disc_q <= '0;
    else if (key_hit)                disc_q <= settle;
    else if (accept && disc_q != '0) disc_q <= disc_q - SETTLE_W'(1);
  end

  // averaging runs
  adc_trim_avg #(.DATA_W(DATA_W), .LOG_MAX(RUN_LOG_MAX), .LOG_W(LOG_W)) u_avg (
    .clk, .rst, .start(start_req), .log_n(run_log),
    .smp_valid(smp_to_avg), .smp_data(in_data),
    .active(cal_active), .fin(avg_fin), .avg(avg_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q    <= CAL_NONE;
      cal_pga_q <= '0;
    end else if (start_req) begin
      kind_q    <= start_kind;
      cal_pga_q <= pga;
    end
  end

  // gain from the two full-scale averages
  logic signed [SUM_W-1:0] span, half;
  always_comb begin
    if (kind_q == CAL_POS) span = SUM_W'(avg_val) - SUM_W'(neg_q);
    else                   span = SUM_W'(pos_q)   - SUM_W'(avg_val);
    half = span >>> 1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q  <= DATA_W'(1 << FRAC_W);
      neg_q  <= -DATA_W'(1 << FRAC_W);
      gain_q <= GAIN_ONE;
    end else if (avg_fin && (kind_q == CAL_POS || kind_q == CAL_NEG)) begin
      if (kind_q == CAL_POS) pos_q <= avg_val;
      else                   neg_q <= avg_val;
      if (half > 0) gain_q <= half[DATA_W-1:0];
    end
  end

  // per-gain-setting offset store
  logic signed [DATA_W-1:0] off_new;
  assign off_new = (avg_val == SMIN) ? SMAX : -avg_val;

  always_ff @(posedge clk) begin
    if (avg_fin && kind_q == CAL_ZERO) off_mem[cal_pga_q] <= off_new;
  end

  always_ff @(posedge clk) begin
    if (rst)                               off_vld <= '0;
    else if (avg_fin && kind_q == CAL_ZERO) off_vld[cal_pga_q] <= 1'b1;
  end

  assign off_cur = off_vld[pga] ? off_mem[pga] : '0;

  // correction datapath
  assign sum     = SUM_W'($signed(in_data)) + SUM_W'($signed(off_cur));
  assign mag     = sum[SUM_W-1] ? SUM_W'(-sum) : SUM_W'(sum);
  assign div_num = NUM_W'(mag) << FRAC_W;

  adc_trim_div #(.NUM_W(NUM_W), .DEN_W(DATA_W)) u_div (
    .clk, .rst, .start(div_go), .num(div_num), .den(gain_q),
    .busy(div_busy), .done(div_done), .quo(div_quo)
  );

  always_ff @(posedge clk) begin
    if (rst)         neg_q_flag <= 1'b0;
    else if (div_go) neg_q_flag <= sum[SUM_W-1];
  end

  logic [DATA_W-1:0] sat_val;
  always_comb begin
    if (neg_q_flag)
      sat_val = (div_quo > NUM_W'(SMAX) + NUM_W'(1)) ? SMIN : DATA_W'(-div_quo[DATA_W-1:0]);
    else
      sat_val = (div_quo > NUM_W'(SMAX)) ? SMAX : div_quo[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= pass_go || div_done;
      if (pass_go)       out_data <= in_data;
      else if (div_done) out_data <= sat_val;
    end
  end
endmodule

// File: rtl/adc_trim_engine_chk.sv
module adc_trim_engine_chk #(
  parameter int DATA_W      = 16,
  parameter int SETTLE_W    = 8,
  parameter int LOG_W       = 4,
  parameter int RUN_LOG_MIN = 4,
  parameter int RUN_LOG_MAX = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic                in_ready,
  input logic [DATA_W-1:0]   in_data,
  input logic                out_valid,
  input logic [DATA_W-1:0]   out_data,
  input logic                reg_rd,
  input logic [2:0]          reg_addr,
  input logic                corr_en,
  input logic                cal_active,
  input logic [SETTLE_W-1:0] disc_q,
  input logic [SETTLE_W-1:0] settle,
  input logic                key_hit,
  input logic                div_busy,
  input logic [DATA_W-1:0]   gain_q,
  input logic [LOG_W-1:0]    run_log,
  input logic                cal_done,
  input logic                avg_fin
);
  logic acc;
  assign acc = in_valid && in_ready;

  p_passthru_r1: assert property (@(posedge clk) disable iff (rst)
    (acc && disc_q == '0 && !cal_active && !corr_en) |=> (out_valid && out_data == $past(in_data)));

  p_no_out_in_run_r2: assert property (@(posedge clk) disable iff (rst)
    (acc && disc_q == '0 && cal_active) |=> !out_valid);

  p_runlog_range_r2: assert property (@(posedge clk) disable iff (rst)
    (run_log >= LOG_W'(RUN_LOG_MIN)) && (run_log <= LOG_W'(RUN_LOG_MAX)));

  p_gain_nonzero_r3: assert property (@(posedge clk) disable iff (rst)
    gain_q != '0);

  p_busy_holds_r8: assert property (@(posedge clk) disable iff (rst)
    div_busy |-> !in_ready);

  p_key_load_r9: assert property (@(posedge clk) disable iff (rst)
    key_hit |=> disc_q == $past(settle));

  p_discard_r9: assert property (@(posedge clk) disable iff (rst)
    (acc && disc_q != '0) |=> !out_valid);

  p_done_clear_r10: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == 3'd4 && !avg_fin) |=> !cal_done);

  p_done_set_r10: assert property (@(posedge clk) disable iff (rst)
    avg_fin |=> cal_done);
endmodule

bind adc_trim_engine adc_trim_engine_chk #(
  .DATA_W(DATA_W), .SETTLE_W(SETTLE_W), .LOG_W(LOG_W),
  .RUN_LOG_MIN(RUN_LOG_MIN), .RUN_LOG_MAX(RUN_LOG_MAX)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
  .out_valid(out_valid), .out_data(out_data), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .corr_en(corr_en), .cal_active(cal_active), .disc_q(disc_q), .settle(settle),
  .key_hit(key_hit), .div_busy(div_busy), .gain_q(gain_q), .run_log(run_log),
  .cal_done(cal_done), .avg_fin(avg_fin)
);

// File: tb/test_adc_trim_engine.sv
module test_adc_trim_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = '0;
  logic        out_valid;
  logic [15:0] out_data;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0, reg_rdata;

  int nvec = 0, nbad = 0;
  int gain_m = 16384;
  int off_m [8];
  logic [15:0] rv;

  always #2 clk = ~clk;

  adc_trim_engine i_adc_trim_engine (
    .clk, .rst, .in_valid, .in_ready, .in_data, .out_valid, .out_data,
    .reg_wr, .reg_rd, .reg_addr, .reg_wdata, .reg_rdata
  );

  // {correction enable, gain setting, raw word}
  localparam logic [19:0] VEC [12] = '{
    {1'b0, 3'd5, 16'h3039}, {1'b0, 3'd0, 16'h8000}, {1'b1, 3'd0, 16'h03E8},
    {1'b1, 3'd3, 16'h03E8}, {1'b1, 3'd0, 16'h7FFF}, {1'b1, 3'd0, 16'h8000},
    {1'b1, 3'd3, 16'hF830}, {1'b1, 3'd1, 16'h01F4}, {1'b1, 3'd0, 16'hFFFF},
    {1'b1, 3'd3, 16'hFFF9}, {1'b0, 3'd3, 16'hFFF9}, {1'b1, 3'd7, 16'h7FFF}
  };

  function automatic int model(int raw, int off, int g);
    longint s, q;
    s = longint'(raw + off) * 16384;
    q = s / g;
    if (q > 32767) q = 32767;
    if (q < -32768) q = -32768;
    return int'(q);
  endfunction

  task automatic chk(input int act, input int exp, input string req);
    nvec++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [2:0] a, input logic [15:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rreg(input logic [2:0] a, output logic [15:0] d);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic push(input logic [15:0] d);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_data = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_out(input int exp, input string req);
    int waited = 0;
    while (!out_valid && waited < 80) begin @(negedge clk); waited++; end
    if (!out_valid) begin
      nvec++; nbad++;
      $display("FAIL %s: got no output expected %0d", req, exp);
    end else chk(int'($signed(out_data)), exp, req);
    @(negedge clk);
  endtask

  task automatic expect_none(input string req);
    int seen = 0;
    for (int i = 0; i < 12; i++) begin
      if (out_valid) seen = 1;
      @(negedge clk);
    end
    chk(seen, 0, req);
  endtask

  task automatic cal_run(input int kind, input int pga, input int base, input int n);
    wreg(3'd0, 16'(64 + kind * 16 + pga * 2 + 1));
    @(negedge clk);
    for (int i = 0; i < n; i++) push(16'(base + ((i % 2 == 0) ? 3 : -3)));
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) off_m[i] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // reset state (R11 reads)
    rreg(3'd5, rv); chk(int'(rv), 16384, "R3 reset gain");
    rreg(3'd1, rv); chk(int'(rv), 4, "R2 reset runlog");
    rreg(3'd2, rv); chk(int'(rv), 8, "R9 reset settle");
    rreg(3'd4, rv); chk(int'(rv), 0, "R10 reset status");
    rreg(3'd6, rv); chk(int'(rv), 0, "R5 reset offset");

    // rejected full-scale run with nonzero gain setting (R4)
    wreg(3'd0, 16'(64 + 16 + 2 * 2 + 1));
    repeat (3) @(negedge clk);
    rreg(3'd4, rv); chk(int'(rv), 0, "R4 rejected run status");
    push(16'd777); expect_out(777, "R4 no run, R6 unity gain");
    rreg(3'd5, rv); chk(int'(rv), 16384, "R4 gain unchanged");

    // positive full-scale run, 16 samples averaging 20000 (R2, R3)
    cal_run(1, 0, 20000, 16);
    rreg(3'd4, rv); chk(int'(rv), 1, "R10 done set");
    rreg(3'd4, rv); chk(int'(rv), 0, "R10 done cleared by read");
    rreg(3'd5, rv); chk(int'(rv), 18192, "R3 gain after positive run");

    // run length clamps (R2)
    wreg(3'd1, 16'd2);  rreg(3'd1, rv); chk(int'(rv), 4, "R2 clamp low");
    wreg(3'd1, 16'd15); rreg(3'd1, rv); chk(int'(rv), 8, "R2 clamp high");
    wreg(3'd1, 16'd5);
    cal_run(2, 0, -12000, 32);
    rreg(3'd5, rv); chk(int'(rv), 16000, "R3 gain after negative run");
    gain_m = 16000;
    wreg(3'd1, 16'd4);

    // zero runs (R5)
    cal_run(3, 0, 100, 16);  off_m[0] = -100;
    cal_run(3, 3, -50, 16);  off_m[3] = 50;
    rreg(3'd6, rv); chk(int'($signed(rv)), 50, "R5 offset gain setting 3");
    wreg(3'd0, 16'd1);
    rreg(3'd6, rv); chk(int'($signed(rv)), -100, "R5 offset gain setting 0");

    // vector table (R1, R6, R7)
    for (int v = 0; v < 12; v++) begin
      logic corr;
      int pga, raw, exp;
      corr = VEC[v][19];
      pga  = int'(VEC[v][18:16]);
      raw  = int'($signed(VEC[v][15:0]));
      exp  = corr ? model(raw, off_m[pga], gain_m) : raw;
      wreg(3'd0, 16'(pga * 2 + int'(corr)));
      push(VEC[v][15:0]);
      expect_out(exp, corr ? "R6 R7 corrected word" : "R1 pass-through");
    end

    // busy divider holds ready low (R8)
    wreg(3'd0, 16'd1);
    push(16'd10);
    chk(int'(in_ready), 0, "R8 ready low while dividing");
    expect_out(model(10, -100, 16000), "R8 corrected result");

    // restart key (R9)
    wreg(3'd0, 16'd0);
    wreg(3'd3, 16'h1234);
    push(16'd55); expect_out(55, "R9 wrong key ignored");
    wreg(3'd3, 16'h5AF0);
    @(negedge clk);
    for (int i = 0; i < 8; i++) push(16'(i + 1));
    expect_none("R9 settling samples discarded");
    push(16'd99); expect_out(99, "R9 first word after settling");

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule